// File: doc/BRIEF.md
# Gated Clock-Enable Divider

This block derives a clock-enable pulse stream for one peripheral branch from a source tick stream. It never creates a new clock: every flop downstream stays on `clk` and qualifies itself with `en_o`. The source is either a reference tick or a PLL tick. An optional one-bit selector picks between them, and when the selector is not built, the reference tick is used.

The ratio is read from a divider field in a 32-bit configuration word. Each instance decodes that field in one of four ways, fixed at build time:
- no divider, where every source tick passes through;
- field plus one;
- twice the field plus one;
- two shifted left by the field.

An optional gate bit switches the branch on and off. A branch built without a gate always runs. Changes to the divider, the gate and the source selector wait for the end of the current enable period, so no short period ever reaches the consumer.

Configuration arrives on a single write port. Word 0 holds the gate bit, word 1 holds the divider field and word 2 holds the selector bit. All three bit positions are parameters.

Top module: `clk_en_divider`

## Requirements
- R1: After reset, `en_o` is low, the gate is off, the divider field is zero, the counter is clear and the selector picks the reference tick.
- R2: With MODE=1 and divider field value v, `en_o` pulses once every v+1 source ticks. With v=0 it pulses on every source tick.
- R3: With MODE=2, `en_o` pulses once every 2*(v+1) source ticks.
- R4: With MODE=3, `en_o` pulses once every 2<<v source ticks (2, 4, 8, ...).
- R5: With MODE=0, `en_o` pulses on every source tick and the divider field has no effect.
- R6: The divider field is bits [DIV_SHIFT+DIV_W-1:DIV_SHIFT] of the word written at `cfg_addr`=1. All other bits of that word are ignored.
- R7: The gate is bit GATE_BIT of the word written at `cfg_addr`=0, where 1 means on. When the gate is cleared, the period already running completes with its pulse, and `en_o` then stays low until the gate is set again. All other bits of the word are ignored.
- R8: An instance with HAS_GATE=0 keeps pulsing whatever is written to the gate word.
- R9: The selector is bit MUX_BIT of the word written at `cfg_addr`=2, where 0 selects `ref_tick` and 1 selects `pll_tick`. A new selector value takes effect at a period boundary. With HAS_MUX=0 the selector bit is ignored and `ref_tick` is used.
- R10: A divider write made during a period does not shorten or stretch that period. The new ratio applies from the next period.
- R11: Each pulse comes from a flop. It rises on the clock edge after the edge that samples the terminal source tick, and it lasts one cycle unless the ratio is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick | input | 1 | Reference source tick, one cycle per source period |
| pll_tick | input | 1 | PLL source tick, one cycle per source period |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Word select: 0 gate, 1 divider, 2 selector, 3 unused |
| cfg_wdata | input | 32 | Configuration write data |
| en_o | output | 1 | Divided clock-enable pulse |

## Verification
The most likely internal faults are a wrong terminal value and a counter that misses its wrap. Either one shows at the port as a wrong spacing between pulses, and that spacing can be measured within two periods of the new setting. A load strobe applied at the wrong moment produces a single odd-length period that straddles the write. The bench therefore measures the interval that contains each write, as well as the steady-state intervals. A gate or selector that acts at once, instead of at the period boundary, shows up the same way: as one missing pulse or one extra pulse near the write.

// File: rtl/clk_en_divider.sv
module clk_en_divider #(
  parameter int MODE      = 1,
  parameter int DIV_W     = 4,
  parameter int DIV_SHIFT = 0,
  parameter int GATE_BIT  = 0,
  parameter int MUX_BIT   = 0,
  parameter bit HAS_GATE  = 1'b1,
  parameter bit HAS_MUX   = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ref_tick,
  input  logic        pll_tick,
  input  logic        cfg_we,
  input  logic [1:0]  cfg_addr,
  input  logic [31:0] cfg_wdata,
  output logic        en_o
);

  localparam int CNT_W = (MODE == 3) ? (1 << DIV_W) :
                         (MODE == 2) ? DIV_W + 1 :
                         (MODE == 1) ? DIV_W : 1;

  logic             gate_q, mux_q, run_q, sel_q, en_q;
  logic [DIV_W-1:0] field_q;
  logic [CNT_W-1:0] cnt_q, term_q, pend;
  logic             src_tick, at_term, wrap, load, gate_on, sel_next;
  logic             unused_bits;

  assign src_tick    = sel_q ? pll_tick : ref_tick;
  assign at_term     = (cnt_q == term_q);
  assign wrap        = run_q & src_tick & at_term;
  assign load        = ~run_q | wrap;
  assign gate_on     = HAS_GATE ? gate_q : 1'b1;
  assign sel_next    = HAS_MUX ? mux_q : 1'b0;
  assign en_o        = en_q;
  assign unused_bits = ^{cfg_wdata, field_q};

  generate
    if (MODE == 3) begin : g_pow2
      assign pend = (CNT_W'(2) << field_q) - CNT_W'(1);
    end else if (MODE == 2) begin : g_double
      assign pend = CNT_W'({field_q, 1'b1});
    end else if (MODE == 1) begin : g_plus1
      assign pend = CNT_W'(field_q);
    end else begin : g_none
      assign pend = '0;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q  <= 1'b0;
      mux_q   <= 1'b0;
      field_q <= '0;
    end else if (cfg_we) begin
      case (cfg_addr)
        2'd0:    gate_q  <= cfg_wdata[GATE_BIT];
        2'd1:    field_q <= cfg_wdata[DIV_SHIFT +: DIV_W];
        2'd2:    mux_q   <= cfg_wdata[MUX_BIT];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      sel_q  <= 1'b0;
      term_q <= '0;
      cnt_q  <= '0;
      en_q   <= 1'b0;
    end else begin
      if (load) begin
        term_q <= pend;
        sel_q  <= sel_next;
        run_q  <= gate_on;
      end
      if (!run_q)
        cnt_q <= '0;
      else if (src_tick)
        cnt_q <= at_term ? '0 : cnt_q + CNT_W'(1);
      en_q <= wrap;
    end
  end

endmodule

// File: rtl/clk_en_divider_chk.sv
module clk_en_divider_chk #(
  parameter int CNT_W    = 4,
  parameter bit HAS_GATE = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             src_tick,
  input logic             run_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] term_q,
  input logic             sel_q,
  input logic             en_o
);

  // R10
  term_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !(src_tick && cnt_q == term_q)) |=> ($stable(term_q) && $stable(sel_q)));

  // R9
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !src_tick) |=> $stable(sel_q));

  // R7
  idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |=> !en_o);

  // R11
  pulse_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_o |-> ($past(src_tick) && $past(run_q)));

  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= term_q);

  // R1
  idle_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> (cnt_q == '0));

  // R8
  always_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!HAS_GATE && $past(rst_n)) |-> run_q);

endmodule

bind clk_en_divider clk_en_divider_chk #(.CNT_W(CNT_W), .HAS_GATE(HAS_GATE)) u_chk (
  .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .run_q(run_q),
  .cnt_q(cnt_q), .term_q(term_q), .sel_q(sel_q), .en_o(en_o)
);

// File: tb/clk_en_divider_bench.sv
`timescale 1ns/1ps
module clk_en_divider_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_tick = 1'b0;
  logic        pll_tick = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [3:0]  en;

  int checks = 0, errs = 0, cyc = 0, ref_k = 1;
  int per[4], last[4], pc[4];
  bit prev2 = 0, wide = 0, done = 0;

  always #5 clk = ~clk;

  clk_en_divider #(.MODE(1), .DIV_W(3), .DIV_SHIFT(4), .GATE_BIT(5), .MUX_BIT(2),
    .HAS_GATE(1'b1), .HAS_MUX(1'b1)) u_clk_en_divider (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .pll_tick(pll_tick), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .en_o(en[0]));
  clk_en_divider #(.MODE(2), .DIV_W(3), .DIV_SHIFT(4), .GATE_BIT(5), .MUX_BIT(2),
    .HAS_GATE(1'b1), .HAS_MUX(1'b0)) u_dbl (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .pll_tick(pll_tick), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .en_o(en[1]));
  clk_en_divider #(.MODE(3), .DIV_W(3), .DIV_SHIFT(4), .GATE_BIT(5), .MUX_BIT(2),
    .HAS_GATE(1'b1), .HAS_MUX(1'b0)) u_pow (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .pll_tick(pll_tick), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .en_o(en[2]));
  clk_en_divider #(.MODE(0), .DIV_W(3), .DIV_SHIFT(4), .GATE_BIT(5), .MUX_BIT(2),
    .HAS_GATE(1'b0), .HAS_MUX(1'b1)) u_none (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .pll_tick(pll_tick), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .en_o(en[3]));

  initial for (int i = 0; i < 4; i++) begin per[i] = 0; last[i] = 0; pc[i] = 0; end

  always @(negedge clk) begin
    cyc++;
    for (int i = 0; i < 4; i++)
      if (en[i] === 1'b1) begin per[i] = cyc - last[i]; last[i] = cyc; pc[i]++; end
    if (en[2] === 1'b1 && prev2) wide = 1;
    prev2 = (en[2] === 1'b1);
    ref_tick = ((cyc % ref_k) == 0);
    pll_tick = ((cyc % 2) == 0);
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic div(input int v);
    wr(2'd1, 32'hFFFF_FF8F | (32'(v) << 4));
  endtask

  initial begin
    int base, b3;
    repeat (5) begin
      @(negedge clk); #1;
      chk("R1 en low in reset", int'(en), 0);
    end
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    #1;
    chk("R1 gated units idle", pc[0] + pc[1] + pc[2], 0);
    chk("R8 ungated unit runs", int'(pc[3] > 10), 1);

    wr(2'd0, 32'h0000_0020);
    // R1: selector default is ref_tick (pll_tick would double these periods)
    for (int v = 0; v < 8; v++) begin
      div(v);
      repeat (700) @(negedge clk);
      #1;
      chk("R2 plus-one ratio", per[0], v + 1);
      chk("R3 double ratio", per[1], 2 * (v + 1));
      chk("R4 power-of-two ratio", per[2], 2 << v);
      chk("R5 none mode every tick", per[3], 1);
    end
    ref_k = 3;
    for (int j = 0; j < 3; j++) begin
      int v;
      v = (j == 0) ? 0 : (j == 1) ? 2 : 5;
      div(v);
      repeat (2200) @(negedge clk);
      #1;
      chk("R2 R6 plus-one slow ticks", per[0], 3 * (v + 1));
      chk("R3 double slow ticks", per[1], 6 * (v + 1));
      chk("R4 pow2 slow ticks", per[2], 3 * (2 << v));
      chk("R5 none slow ticks", per[3], 3);
    end
    ref_k = 1;
    chk("R11 single-cycle pulses", int'(wide), 0);

    div(7);
    repeat (40) @(negedge clk);
    @(posedge en[0]); #1;
    repeat (2) @(negedge clk);
    div(1);
    @(posedge en[0]); @(negedge clk); #1;
    chk("R10 period spanning write", per[0], 8);
    @(posedge en[0]); @(negedge clk); #1;
    chk("R10 new ratio next period", per[0], 2);

    div(7);
    repeat (40) @(negedge clk);
    @(posedge en[0]); #1;
    base = pc[0]; b3 = pc[3];
    wr(2'd0, 32'hFFFF_FFDF);
    repeat (40) @(negedge clk);
    #1;
    chk("R7 running period completes then stops", pc[0] - base, 2);
    chk("R7 last period full length", per[0], 8);
    chk("R8 ignores gate clear", int'((pc[3] - b3) > 30), 1);

    wr(2'd0, 32'h0000_0020);
    div(3);
    wr(2'd2, 32'h0);
    repeat (100) @(negedge clk);
    #1;
    chk("R9 ref selected", per[0], 4);
    chk("R9 none ref", per[3], 1);
    wr(2'd2, 32'h0000_0004);
    repeat (100) @(negedge clk);
    #1;
    chk("R9 pll selected", per[0], 8);
    chk("R9 no-mux unit ignores bit", per[1], 8);
    chk("R9 none pll", per[3], 2);
    wr(2'd2, 32'hFFFF_FFFB);
    repeat (100) @(negedge clk);
    #1;
    chk("R9 only MUX_BIT matters", per[0], 4);

    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errs);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      checks++; errs++;
      $display("FAIL watchdog actual 1 expected 0");
      $display("CHECKS %0d ERRORS %0d", checks, errs);
      $finish;
    end
  end

endmodule